// File: doc/BRIEF.md
# Half-Bridge PWM Channel Bank

This block turns a shared, externally generated period counter into pulse-width modulated drive for a set of half-bridges. Every channel produces two signals: a high-side drive output that follows the programmed duty cycle, and a driver-enable output. The driver-enable output is high when the half-bridge driver is released from shutdown and low when the driver is shut down. Each channel compares the common counter against its own match word. A set of shadow registers holds the match word and the two enable bits, so that new settings take effect only at a period boundary.

New settings come in through a flat match bus, per-channel enable vectors and a data-valid flag. The shadow registers copy them only on a clock where both the wrap pulse and data-valid are high, so a half-written update is never used. A failsafe input turns every driver off on the next clock and takes priority over all other inputs.

Each channel is a two-state machine. In `ST_IDLE` (the state after reset) both outputs are held low. The transition `load` (wrap pulse and data-valid high on the same clock) moves the channel to `ST_RUN`. The channel stays in `ST_RUN` until the next reset, and further loads refresh the shadow registers while the channel remains there.

Top module: `hb_pwm_bank`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every `pwm_hi` and `drv_en` bit is 0.
- R2: A channel stays in `ST_IDLE`, with both outputs 0, until the first clock on which `wrap` and `upd_valid` are both 1.
- R3: In `ST_RUN`, with the high-side enable set and failsafe low, `pwm_hi` is 1 exactly when the counter value sampled at the previous clock edge was below the active match word. A match of 0 gives 0% duty, and a match of all ones keeps the output high for every count except the last.
- R4: The match word and both enables are copied into the shadow registers only on a clock where `wrap` and `upd_valid` are both 1. Inputs that change at any other time have no effect on the outputs. A loaded value is in effect from the count presented on that same clock.
- R5: When the shadow high-side enable is 0, `pwm_hi` is 0. The output `drv_en` equals the shadow driver enable while the channel is in `ST_RUN` and failsafe is low.
- R6: A 1 on `failsafe` drives both outputs of every channel to 0 on the next clock, whatever the enables or match words are.
- R7: The channels share `cnt` and `wrap` but have independent match words and enables. Channel k uses `match[k*W +: W]`, `en_hi[k]` and `en_drv[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt | input | W (11) | Shared period counter value |
| wrap | input | 1 | One-cycle pulse on the clock where the counter is back at zero |
| upd_valid | input | 1 | The incoming settings are consistent |
| failsafe | input | 1 | Turns all drivers off |
| en_hi | input | NCH (3) | Per-channel high-side enable |
| en_drv | input | NCH (3) | Per-channel driver enable (1 = release shutdown) |
| match | input | NCH*W | Packed per-channel match words |
| pwm_hi | output | NCH | Registered high-side PWM outputs |
| drv_en | output | NCH | Registered driver-enable outputs (0 = driver off) |

## Verification
Each output depends on the inputs present at one rising edge and is due one clock later. This applies to the compare result, to a shadow load and to the failsafe mask. The bench applies the inputs on the falling edge and updates a reference model of the shadow registers and the state at that moment. It compares the outputs at the next falling edge, one full register stage later. Settings that change away from the wrap pulse are expected to leave the outputs unchanged, and the outputs are checked every cycle to confirm this.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } chan_state_e;
endpackage

// File: rtl/hb_pwm_shadow.sv
module hb_pwm_shadow #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] match_in,
    input  logic         en_hi_in,
    input  logic         en_drv_in,
    output logic [W-1:0] match_q,
    output logic         en_hi_q,
    output logic         en_drv_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q  <= '0;
            en_hi_q  <= 1'b0;
            en_drv_q <= 1'b0;
        end else if (load) begin
            match_q  <= match_in;
            en_hi_q  <= en_hi_in;
            en_drv_q <= en_drv_in;
        end
    end

    // R4
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(match_q) && $stable(en_hi_q) && $stable(en_drv_q)));
endmodule

// File: rtl/hb_pwm_chan.sv
module hb_pwm_chan
    import hb_pwm_pkg::*;
#(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         wrap,
    input  logic         upd_valid,
    input  logic         failsafe,
    input  logic         en_hi_in,
    input  logic         en_drv_in,
    input  logic [W-1:0] match_in,
    output logic         pwm_hi,
    output logic         drv_en
);
    chan_state_e  state_q, state_d;
    logic         load;
    logic [W-1:0] sh_match;
    logic         sh_en_hi, sh_en_drv;
    logic [W-1:0] eff_match;
    logic         eff_en_hi, eff_en_drv;

    assign load = wrap && upd_valid;

    hb_pwm_shadow #(.W(W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .match_in  (match_in),
        .en_hi_in  (en_hi_in),
        .en_drv_in (en_drv_in),
        .match_q   (sh_match),
        .en_hi_q   (sh_en_hi),
        .en_drv_q  (sh_en_drv)
    );

    // A load is in effect from the count presented on the same clock
    always_comb begin
        eff_match  = load ? match_in  : sh_match;
        eff_en_hi  = load ? en_hi_in  : sh_en_hi;
        eff_en_drv = load ? en_drv_in : sh_en_drv;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_hi <= 1'b0;
            drv_en <= 1'b0;
        end else begin
            unique case (state_d)
                ST_IDLE: begin
                    pwm_hi <= 1'b0;
                    drv_en <= 1'b0;
                end
                ST_RUN: begin
                    pwm_hi <= !failsafe && eff_en_hi && (cnt < eff_match);
                    drv_en <= !failsafe && eff_en_drv;
                end
                default: begin
                    pwm_hi <= 1'b0;
                    drv_en <= 1'b0;
                end
            endcase
        end
    end

    // R6
    failsafe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        failsafe |=> (!pwm_hi && !drv_en));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load) |=> (!pwm_hi && !drv_en));
    // R3
    duty_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_hi |-> ($past(cnt) < sh_match));
    // R5
    hi_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_hi |-> sh_en_hi);
endmodule

// File: rtl/hb_pwm_bank.sv
module hb_pwm_bank #(
    parameter int W   = 11,
    parameter int NCH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     cnt,
    input  logic             wrap,
    input  logic             upd_valid,
    input  logic             failsafe,
    input  logic [NCH-1:0]   en_hi,
    input  logic [NCH-1:0]   en_drv,
    input  logic [NCH*W-1:0] match,
    output logic [NCH-1:0]   pwm_hi,
    output logic [NCH-1:0]   drv_en
);
    for (genvar k = 0; k < NCH; k++) begin : g_chan
        hb_pwm_chan #(.W(W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt),
            .wrap      (wrap),
            .upd_valid (upd_valid),
            .failsafe  (failsafe),
            .en_hi_in  (en_hi[k]),
            .en_drv_in (en_drv[k]),
            .match_in  (match[k*W +: W]),
            .pwm_hi    (pwm_hi[k]),
            .drv_en    (drv_en[k])
        );
    end
endmodule

// File: tb/hb_pwm_bank_tb_top.sv
module hb_pwm_bank_tb_top;
    localparam int W      = 11;
    localparam int NCH    = 3;
    localparam int PERIOD = 1 << W;
    localparam int NPER   = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     cnt = '0;
    logic             wrap = 1'b0;
    logic             upd_valid = 1'b0;
    logic             failsafe = 1'b0;
    logic [NCH-1:0]   en_hi = '0;
    logic [NCH-1:0]   en_drv = '0;
    logic [NCH*W-1:0] match = '0;
    logic [NCH-1:0]   pwm_hi;
    logic [NCH-1:0]   drv_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_pwm_bank #(.W(W), .NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .upd_valid(upd_valid),
        .failsafe(failsafe), .en_hi(en_hi), .en_drv(en_drv), .match(match),
        .pwm_hi(pwm_hi), .drv_en(drv_en)
    );

    // Reference model state
    bit         m_run   [NCH];
    logic [W-1:0] m_match [NCH];
    bit         m_hi    [NCH];
    bit         m_drv   [NCH];
    bit         exp_hi  [NCH];
    bit         exp_drv [NCH];
    string      exp_tag;

    function automatic bit f_hi(bit run, bit fs, bit en, logic [W-1:0] c, logic [W-1:0] m);
        return run && !fs && en && (c < m);
    endfunction

    function automatic bit f_drv(bit run, bit fs, bit en);
        return run && !fs && en;
    endfunction

    task automatic check(string tag, int k, bit act, bit exp, string name);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s ch%0d %s actual=%0b expected=%0b t=%0t", tag, k, name, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit ld;
        ld = wrap && upd_valid;
        for (int k = 0; k < NCH; k++) begin
            if (ld) begin
                m_run[k]   = 1'b1;
                m_match[k] = match[k*W +: W];
                m_hi[k]    = en_hi[k];
                m_drv[k]   = en_drv[k];
            end
            exp_hi[k]  = f_hi(m_run[k], failsafe, m_hi[k], cnt, m_match[k]);
            exp_drv[k] = f_drv(m_run[k], failsafe, m_drv[k]);
        end
    endtask

    initial begin
        for (int k = 0; k < NCH; k++) begin
            m_run[k] = 0; m_match[k] = '0; m_hi[k] = 0; m_drv[k] = 0;
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        for (int k = 0; k < NCH; k++) begin
            check("R1", k, pwm_hi[k], 1'b0, "pwm_hi");
            check("R1", k, drv_en[k], 1'b0, "drv_en");
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NCH; k++) begin
            check("R1", k, pwm_hi[k], 1'b0, "pwm_hi");
            check("R1", k, drv_en[k], 1'b0, "drv_en");
        end
        for (int cyc = 0; cyc < NPER * PERIOD; cyc++) begin
            int p;
            p = cyc / PERIOD;
            cnt  = W'(cyc % PERIOD);
            wrap = (cnt == '0) && (cyc > 0);
            if (p == 0) begin
                // R2: settings offered but never valid
                upd_valid = 1'b0;
                failsafe  = 1'b0;
                en_hi     = '1;
                en_drv    = '1;
                match     = {NCH{W'(PERIOD / 2)}};
                exp_tag   = "R2";
            end else if (p == 1) begin
                // R3/R7: distinct matches per channel, including 0 and all ones
                upd_valid = 1'b1;
                failsafe  = 1'b0;
                en_hi     = '1;
                en_drv    = 3'b101;
                match     = {W'(1), W'(PERIOD - 1), W'(0)};
                exp_tag   = "R7";
            end else if (p == 2) begin
                // R4: only the value present at the wrap loads
                upd_valid = 1'b1;
                failsafe  = 1'b0;
                en_hi     = wrap ? 3'b111 : 3'($urandom);
                en_drv    = wrap ? 3'b111 : 3'($urandom);
                for (int k = 0; k < NCH; k++)
                    match[k*W +: W] = wrap ? W'(100 + 500 * k) : W'($urandom);
                exp_tag   = "R4";
            end else begin
                // Random mix of settings, valid flag and failsafe
                upd_valid = ($urandom % 3) != 0;
                failsafe  = ($urandom % 50) == 0;
                en_hi     = 3'($urandom | $urandom);
                en_drv    = 3'($urandom);
                for (int k = 0; k < NCH; k++)
                    match[k*W +: W] = W'($urandom);
                exp_tag   = "R3";
            end
            model_step();
            @(negedge clk);
            for (int k = 0; k < NCH; k++) begin
                string t;
                t = exp_tag;
                if (failsafe) t = "R6";
                else if (!m_run[k]) t = "R2";
                else if (exp_tag == "R3" && !m_hi[k]) t = "R5";
                check(t, k, pwm_hi[k], exp_hi[k], "pwm_hi");
                check((t == "R3") ? "R5" : t, k, drv_en[k], exp_drv[k], "drv_en");
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule